// File: doc/BRIEF.md
# Processor Status Byte with Sense Inputs and Control Flags

This block holds the 8-bit status byte of a small processor core. It stores carry/link, overflow and interrupt-enable state, plus three control flags that leave the block as output pins the moment they change. It also carries two external sense lines into the byte as read-only bits.

The processor reads the whole byte at any time and may overwrite it as a byte. The sense positions ignore writes. The ALU sets carry and overflow on its own through dedicated update strobes. Sense line A also serves as the interrupt request whenever interrupt enable is set. Each sense line passes through a two-stage synchronizer before it is used anywhere.

Top module: `status_reg`

## Requirements
- R1: `rd_data` always shows the byte with this layout: bit 7 carry/link, bit 6 overflow, bit 5 synchronized sense B, bit 4 synchronized sense A, bit 3 interrupt enable, bits 2:0 flags 2..0.
- R2: Bits 5 and 4 of `rd_data` show the level `sense_b_in` / `sense_a_in` had two rising clock edges earlier. A byte write never alters them.
- R3: When `wr_en` is 1 at a rising edge, bits 7, 6 and 3:0 take the values of `wr_data` from that edge, unless R7 or R8 overrides them.
- R4: `flag_out` equals the flag bits and changes on the same edge as the write that changes them.
- R5: `irq_req` is 1 exactly when interrupt enable is 1 and the synchronized sense A bit is 1.
- R6: While `rst_n` is 0, carry, overflow, interrupt enable, flags and both synchronizers are cleared, so `rd_data` reads 0x00.
- R7: When `cy_upd` is 1 at an edge, bit 7 takes `cy_val`, even if a byte write happens on the same edge. The write still sets the other bits.
- R8: When `ov_upd` is 1 at an edge, bit 6 takes `ov_val`, even if a byte write happens on the same edge. The write still sets the other bits.
- R9: With no write and no strobe, bits 7, 6 and 3:0 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write enable |
| wr_data | input | 8 | Byte to write |
| cy_upd | input | 1 | Carry update strobe |
| cy_val | input | 1 | New carry value |
| ov_upd | input | 1 | Overflow update strobe |
| ov_val | input | 1 | New overflow value |
| sense_a_in | input | 1 | Asynchronous sense line A |
| sense_b_in | input | 1 | Asynchronous sense line B |
| rd_data | output | 8 | Current status byte |
| flag_out | output | 3 | Control flag pins |
| irq_req | output | 1 | Interrupt request |

## Verification
Writes and ALU strobes take effect on the first rising edge after they are driven, so their results appear one cycle later. Sense levels reach `rd_data` and `irq_req` after the second edge. The driver applies each stimulus on a falling edge and pushes the expected byte, flags and interrupt request for the next edge. The monitor compares them two nanoseconds after that rising edge. Sense expectations come from a two-deep history of the driven levels, so a sense change is checked both one edge after it, when it must not yet appear, and two edges after it, when it must.

// File: rtl/status_reg.sv
module status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cy_upd,
  input  logic       cy_val,
  input  logic       ov_upd,
  input  logic       ov_val,
  input  logic       sense_a_in,
  input  logic       sense_b_in,
  output logic [7:0] rd_data,
  output logic [2:0] flag_out,
  output logic       irq_req
);

  logic [SYNC_STAGES-1:0] sa_sync, sb_sync;
  logic                   cy_q, ov_q, ie_q;
  logic [2:0]             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_sync <= '0;
      sb_sync <= '0;
    end else begin
      sa_sync <= {sa_sync[SYNC_STAGES-2:0], sense_a_in};
      sb_sync <= {sb_sync[SYNC_STAGES-2:0], sense_b_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= '0;
    end else begin
      if (cy_upd)     cy_q <= cy_val;
      else if (wr_en) cy_q <= wr_data[7];
      if (ov_upd)     ov_q <= ov_val;
      else if (wr_en) ov_q <= wr_data[6];
      if (wr_en) begin
        ie_q   <= wr_data[3];
        flag_q <= wr_data[2:0];
      end
    end
  end

  wire sa_s = sa_sync[SYNC_STAGES-1];
  wire sb_s = sb_sync[SYNC_STAGES-1];

  assign rd_data  = {cy_q, ov_q, sb_s, sa_s, ie_q, flag_q};
  assign flag_out = flag_q;
  assign irq_req  = ie_q & sa_s;

endmodule

// File: rtl/status_reg_chk.sv
module status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       cy_upd,
  input logic       cy_val,
  input logic       ov_upd,
  input logic       ov_val,
  input logic       sense_a_in,
  input logic       sense_b_in,
  input logic [7:0] rd_data,
  input logic [2:0] flag_out,
  input logic       irq_req
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_sense_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> rd_data[4] == $past(sense_a_in, 2));
  p_sense_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> rd_data[5] == $past(sense_b_in, 2));
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cy_upd && !ov_upd) |=>
      (rd_data[7:6] == $past(wr_data[7:6]) && rd_data[3:0] == $past(wr_data[3:0])));
  p_flag_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flag_out == $past(wr_data[2:0]));
  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (rd_data[3] && rd_data[4]));
  p_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data[7:6] == 2'b00 && rd_data[3:0] == 4'h0));
  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cy_upd |=> rd_data[7] == $past(cy_val));
  p_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_upd |=> rd_data[6] == $past(ov_val));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cy_upd && !ov_upd) |=>
      ($stable(rd_data[7:6]) && $stable(rd_data[3:0])));

endmodule

bind status_reg status_reg_chk u_chk (.*);

// File: tb/status_reg_bench.sv
module status_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cy_upd = 1'b0, cy_val = 1'b0, ov_upd = 1'b0, ov_val = 1'b0;
  logic       sense_a_in = 1'b0, sense_b_in = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] flag_out;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  logic       m_cy = 0, m_ov = 0, m_ie = 0;
  logic [2:0] m_fl = 0;
  logic       m_sa1 = 0, m_sa2 = 0, m_sb1 = 0, m_sb2 = 0;

  always #5 clk = ~clk;

  status_reg u_status_reg (.*);

  task automatic step(input logic we, input logic [7:0] wd,
                      input logic cu, input logic cv,
                      input logic ou, input logic ovv,
                      input logic sa, input logic sb, input string tag);
    logic [7:0] rd;
    @(negedge clk);
    wr_en = we; wr_data = wd; cy_upd = cu; cy_val = cv;
    ov_upd = ou; ov_val = ovv; sense_a_in = sa; sense_b_in = sb;
    if (cu) m_cy = cv; else if (we) m_cy = wd[7];
    if (ou) m_ov = ovv; else if (we) m_ov = wd[6];
    if (we) begin m_ie = wd[3]; m_fl = wd[2:0]; end
    m_sa2 = m_sa1; m_sa1 = sa;
    m_sb2 = m_sb1; m_sb1 = sb;
    rd = {m_cy, m_ov, m_sb2, m_sa2, m_ie, m_fl};
    exp_q.push_back({rd, m_fl, m_ie & m_sa2});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({rd_data, flag_out, irq_req} !== e) begin
        errors++;
        $display("FAIL %s: rd=%h flag=%b irq=%b expected rd=%h flag=%b irq=%b",
                 t, rd_data, flag_out, irq_req, e[11:4], e[3:1], e[0]);
      end
    end
  end

  initial begin
    #200000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sense_a_in = 1'b1; sense_b_in = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({rd_data, flag_out, irq_req} !== 12'h000) begin
      errors++;
      $display("FAIL R6: rd=%h flag=%b irq=%b expected rd=00 flag=000 irq=0",
               rd_data, flag_out, irq_req);
    end
    @(negedge clk);
    sense_a_in = 1'b0; sense_b_in = 1'b0;
    rst_n = 1'b1;
    step(0, 8'h00, 0, 0, 0, 0, 0, 0, "R6 after release");
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0, "R3 R4 R1 write FF, sense bits stay 0");
    step(0, 8'h00, 0, 0, 0, 0, 1, 0, "R2 sense A one edge, not yet visible");
    step(0, 8'h00, 0, 0, 0, 0, 1, 0, "R2 R5 sense A visible, irq up");
    step(1, 8'h00, 0, 0, 0, 0, 1, 0, "R2 R4 R5 write 00 keeps sense A, irq down");
    step(1, 8'h08, 0, 0, 0, 0, 1, 0, "R5 enable interrupts");
    step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R2 sense change one edge");
    step(0, 8'h00, 0, 0, 0, 0, 0, 1, "R1 R2 R5 sense B bit 5, irq off");
    step(1, 8'h00, 1, 1, 0, 0, 0, 1, "R7 carry strobe beats write");
    step(1, 8'hFF, 0, 0, 1, 0, 1, 0, "R8 overflow strobe beats write");
    step(0, 8'h00, 1, 0, 0, 0, 1, 0, "R7 carry strobe alone, others kept");
    step(0, 8'h00, 0, 0, 1, 1, 1, 1, "R8 overflow strobe alone");
    step(0, 8'h5A, 0, 0, 0, 0, 1, 1, "R9 hold without write");
    step(1, 8'h35, 0, 0, 0, 0, 0, 0, "R2 R3 write with sense bits set is ignored there");
    step(1, 8'h02, 1, 0, 1, 1, 0, 0, "R4 R7 R8 both strobes with write");
    step(0, 8'h00, 0, 0, 0, 0, 0, 0, "R9 hold");
    step(1, 8'hA4, 0, 0, 0, 0, 1, 1, "R3 R4 flag pattern");
    step(0, 8'h00, 0, 0, 0, 0, 1, 1, "R1 R2 final layout");
    step(0, 8'h00, 0, 0, 0, 0, 1, 1, "R9 final hold");
    @(negedge clk);
    wr_en = 0; cy_upd = 0; ov_upd = 0;
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule